// File: doc/BRIEF.md
# I2C Slave with Automatic Clock Stretching

This block is an I2C slave engine. It gives host software time to handle every byte by holding SCL low. It matches either a 7-bit or a 10-bit own address. Received bytes are shifted into a one-byte buffer, and transmitted bytes are shifted out of that same buffer. The slave ACKs or NACKs on the ninth clock. At the falling edge that ends the ninth clock it decides whether to keep the clock low.

Two flags control the hold. The clock-release bit is cleared by the engine and set again by the host. The update-address flag is set during the 10-bit address phases and is cleared when the host writes the own-address register. SCL is pulled low while either of these holds the bus.

Both bus lines pass through a synchronising glitch filter before they are used. START and STOP are recognised from SDA changing while SCL is high. The host is given a single-cycle event pulse for every byte that is acknowledged.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset, neither bus line is driven low, the clock-release bit reads 1, and the buffer-full, update-address and overflow flags read 0.
- R2: In 7-bit mode, an address byte whose upper seven bits equal own-address bits [6:0] is ACKed, and bit 0 of that byte selects read (1) or write (0). Any other address byte is NACKed, and the rest of the transfer is ignored.
- R3: A data byte written to an addressed slave is ACKed and lands in the buffer, received MSB first, with buffer-full set. Every acknowledged byte, whether address or data, gives exactly one single-cycle event pulse.
- R4: Take the case where stretch-on-receive is enabled and buffer-full is still set at the falling edge that ends the ninth clock of a received data byte. Then the clock-release bit is cleared and SCL stays low until the host sets the bit.
- R5: If the host reads the buffer between the eighth falling edge and the end of the ninth clock, buffer-full clears, the release bit stays 1, and SCL is not held.
- R6: With stretch-on-receive disabled, received data bytes never hold SCL.
- R7: A data byte that arrives while buffer-full is still set is NACKed and sets the overflow flag, and the buffer keeps its old value. A host read of the buffer clears the overflow flag.
- R8: In transmit, the release bit is cleared at the end of the ninth clock whenever the buffer is empty, whatever the stretch-on-receive enable says. If the host loaded the buffer before that edge, no hold happens. Bytes are sent MSB first.
- R9: In 10-bit mode, the first address byte is 11110, then own-address bits [9:8], then R/W=0, and it is followed by a byte equal to own-address bits [7:0]. Each of these bytes is ACKed and sets the update-address flag, which holds SCL low without changing the release bit. Any write of the own-address register clears the flag and releases SCL.
- R10: After a full 10-bit match, a repeated START followed by the header byte with R/W=1 is ACKed. It does not set the update-address flag and enters transmit under the R8 rule.
- R11: A STOP clears the 10-bit match, so a later read header without a new match is NACKed.
- R12: A host set of the release bit takes effect on the next cycle, at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (open drain) |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| mode10 | input | 1 | 1 selects 10-bit addressing |
| stretch_rx_en | input | 1 | Enables clock hold after received data bytes |
| own_wr | input | 1 | Own-address write strobe |
| own_wdata | input | 10 | Own-address value |
| buf_wr | input | 1 | Buffer write strobe (transmit data) |
| buf_wdata | input | 8 | Buffer write value |
| buf_rd | input | 1 | Buffer read strobe |
| buf_rdata | output | 8 | Buffer contents |
| buf_full | output | 1 | Buffer-full flag |
| rel_set | input | 1 | Sets the clock-release bit |
| rel | output | 1 | Clock-release bit |
| upd_addr | output | 1 | Update-address flag |
| overflow | output | 1 | Receive overflow flag |
| event_p | output | 1 | One-cycle pulse per acknowledged byte |
| xmit | output | 1 | Engine is in transmit |

## Verification
A wrong hold decision shows on `scl_oe` within a few clocks of the filtered ninth falling edge. The bus master either stalls on a clock that never rises or misses a hold it needed, and `rel` or `upd_addr` shows which rule misfired. A wrong address or overflow decision shows on the ninth-clock ACK bit that the master samples, in the same byte. A shift or load fault shows as a wrong byte in `buf_rdata` or a wrong value read by the master at the end of the byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam logic [4:0] HDR10 = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_TX
  } eng_state_t;

  typedef enum logic [1:0] {
    AK_7B,
    AK_HI,
    AK_LO,
    AK_TXH
  } addr_kind_t;
endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int STABLE_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(STABLE_CYC - 1);

  logic s1_q, s2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      cnt_q  <= '0;
      filt_o <= 1'b1;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q != filt_o) begin
        if (cnt_q == LIM) begin
          filt_o <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_f;
      sda_prev <= sda_f;
    end
  end

  assign start_p = scl_f & scl_prev & sda_prev & ~sda_f;
  assign stop_p  = scl_f & scl_prev & ~sda_prev & sda_f;
  assign rise_p  = scl_f & ~scl_prev;
  assign fall_p  = ~scl_f & scl_prev;
endmodule

// File: rtl/i2cs_core.sv
module i2cs_core
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              mode10_i,
  input  logic              stretch_rx_en_i,
  input  logic              own_wr_i,
  input  logic [ADDR_W-1:0] own_wdata_i,
  input  logic              buf_wr_i,
  input  logic [BYTE_W-1:0] buf_wdata_i,
  input  logic              buf_rd_i,
  input  logic              rel_set_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] buf_rdata_o,
  output logic              buf_full_o,
  output logic              rel_o,
  output logic              ua_o,
  output logic              ovf_o,
  output logic              evt_o,
  output logic              xmit_o
);
  localparam int BCW = $clog2(BYTE_W + 1);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(BYTE_W);

  eng_state_t        state_q;
  addr_kind_t        kind_q;
  logic [BCW-1:0]    bit_q;
  logic              nine_q, ack_q, dir_q, mack_q;
  logic              hi_ok_q, match10_q, tx_ld_q;
  logic [BYTE_W-1:0] rx_sh_q, tx_sh_q, buf_q;
  logic [ADDR_W-1:0] own_q;
  logic              bf_q, rel_q, ua_q, ovf_q, evt_q, sda_oe_q, scl_oe_q;

  logic hdr_ok, match7, bf_eff_tx, bf_eff_rx;
  assign hdr_ok    = (rx_sh_q[7:3] == HDR10) && (rx_sh_q[2:1] == own_q[9:8]);
  assign match7    = (rx_sh_q[7:1] == own_q[6:0]);
  assign bf_eff_tx = bf_q | buf_wr_i;
  assign bf_eff_rx = bf_q & ~buf_rd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      kind_q    <= AK_7B;
      bit_q     <= '0;
      nine_q    <= 1'b0;
      ack_q     <= 1'b0;
      dir_q     <= 1'b0;
      mack_q    <= 1'b0;
      hi_ok_q   <= 1'b0;
      match10_q <= 1'b0;
      tx_ld_q   <= 1'b0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      buf_q     <= '0;
      own_q     <= '0;
      bf_q      <= 1'b0;
      rel_q     <= 1'b1;
      ua_q      <= 1'b0;
      ovf_q     <= 1'b0;
      evt_q     <= 1'b0;
      sda_oe_q  <= 1'b0;
      scl_oe_q  <= 1'b0;
    end else begin
      evt_q    <= 1'b0;
      scl_oe_q <= ~rel_q | ua_q;
      // host side
      if (own_wr_i) begin
        own_q <= own_wdata_i;
        ua_q  <= 1'b0;
      end
      if (buf_wr_i) begin
        buf_q <= buf_wdata_i;
        bf_q  <= 1'b1;
      end
      if (buf_rd_i) begin
        bf_q  <= 1'b0;
        ovf_q <= 1'b0;
      end
      // bus engine
      if (stop_p) begin
        state_q   <= ST_IDLE;
        hi_ok_q   <= 1'b0;
        match10_q <= 1'b0;
        sda_oe_q  <= 1'b0;
        bit_q     <= '0;
        nine_q    <= 1'b0;
      end else if (start_p) begin
        state_q  <= ST_ADDR;
        sda_oe_q <= 1'b0;
        bit_q    <= '0;
        nine_q   <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (rise_p) begin
          if (bit_q != BIT_LAST) begin
            rx_sh_q <= {rx_sh_q[BYTE_W-2:0], sda_f};
            bit_q   <= bit_q + BCW'(1);
          end else begin
            nine_q <= 1'b1;
            mack_q <= ~sda_f;
          end
        end else if (fall_p) begin
          if (bit_q == BIT_LAST && !nine_q) begin
            // eighth falling edge: decide our ACK
            ack_q <= 1'b0;
            case (state_q)
              ST_ADDR: begin
                if (!mode10_i) begin
                  kind_q <= AK_7B;
                  dir_q  <= rx_sh_q[0];
                  ack_q  <= match7;
                  sda_oe_q <= match7;
                end else if (hi_ok_q) begin
                  hi_ok_q  <= 1'b0;
                  kind_q   <= AK_LO;
                  ack_q    <= (rx_sh_q == own_q[7:0]);
                  sda_oe_q <= (rx_sh_q == own_q[7:0]);
                end else if (hdr_ok && !rx_sh_q[0]) begin
                  kind_q   <= AK_HI;
                  ack_q    <= 1'b1;
                  sda_oe_q <= 1'b1;
                end else if (hdr_ok && match10_q) begin
                  kind_q   <= AK_TXH;
                  ack_q    <= 1'b1;
                  sda_oe_q <= 1'b1;
                end
              end
              ST_RX: begin
                if (bf_eff_rx) begin
                  ovf_q <= 1'b1;
                end else begin
                  buf_q    <= rx_sh_q;
                  bf_q     <= 1'b1;
                  ack_q    <= 1'b1;
                  sda_oe_q <= 1'b1;
                end
              end
              default: sda_oe_q <= 1'b0;
            endcase
          end else if (bit_q == BIT_LAST && nine_q) begin
            // end of the ninth clock: hold rules
            bit_q    <= '0;
            nine_q   <= 1'b0;
            sda_oe_q <= 1'b0;
            tx_ld_q  <= 1'b0;
            case (state_q)
              ST_ADDR: begin
                if (ack_q) begin
                  evt_q <= 1'b1;
                  case (kind_q)
                    AK_7B: begin
                      if (dir_q) begin
                        state_q <= ST_TX;
                        if (!bf_eff_tx) rel_q <= 1'b0;
                      end else begin
                        state_q <= ST_RX;
                      end
                    end
                    AK_HI: begin
                      ua_q    <= 1'b1;
                      hi_ok_q <= 1'b1;
                    end
                    AK_LO: begin
                      ua_q      <= 1'b1;
                      match10_q <= 1'b1;
                      state_q   <= ST_RX;
                    end
                    default: begin
                      state_q <= ST_TX;
                      if (!bf_eff_tx) rel_q <= 1'b0;
                    end
                  endcase
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_RX: begin
                if (ack_q) begin
                  evt_q <= 1'b1;
                  if (stretch_rx_en_i && bf_eff_rx) rel_q <= 1'b0;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              default: begin
                evt_q <= 1'b1;
                if (mack_q) begin
                  if (!bf_eff_tx) rel_q <= 1'b0;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
            endcase
          end else if (state_q == ST_TX && bit_q != '0) begin
            tx_sh_q  <= {tx_sh_q[BYTE_W-2:0], 1'b0};
            sda_oe_q <= ~tx_sh_q[BYTE_W-2];
          end
        end else if (state_q == ST_TX && bit_q == '0 && !tx_ld_q && rel_q) begin
          tx_sh_q  <= buf_q;
          bf_q     <= 1'b0;
          sda_oe_q <= ~buf_q[BYTE_W-1];
          tx_ld_q  <= 1'b1;
        end
      end
      if (rel_set_i) rel_q <= 1'b1;
    end
  end

  assign scl_oe_o    = scl_oe_q;
  assign sda_oe_o    = sda_oe_q;
  assign buf_rdata_o = buf_q;
  assign buf_full_o  = bf_q;
  assign rel_o       = rel_q;
  assign ua_o        = ua_q;
  assign ovf_o       = ovf_q;
  assign evt_o       = evt_q;
  assign xmit_o      = (state_q == ST_TX);

  // R12
  rel_set_chk: assert property (@(posedge clk) disable iff (rst) rel_set_i |=> rel_q);
  // R9
  ua_keeps_rel_chk: assert property (@(posedge clk) disable iff (rst) $rose(ua_q) |-> $stable(rel_q));
  // R9
  ua_release_chk: assert property (@(posedge clk) disable iff (rst) (own_wr_i && !fall_p) |=> !ua_q);
  // R7
  ovf_keeps_buf_chk: assert property (@(posedge clk) disable iff (rst) ($rose(ovf_q) && !$past(buf_wr_i)) |-> $stable(buf_q));
  // R3
  evt_single_chk: assert property (@(posedge clk) disable iff (rst) evt_q |=> !evt_q);
  // R2
  sda_when_addressed_chk: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe_q) |-> state_q != ST_IDLE);
  // R4
  hold_on_low_chk: assert property (@(posedge clk) disable iff (rst) $rose(scl_oe_q) |-> !scl_f);
endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
  import i2cs_pkg::*;
#(
  parameter int FILT_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              mode10,
  input  logic              stretch_rx_en,
  input  logic              own_wr,
  input  logic [ADDR_W-1:0] own_wdata,
  input  logic              buf_wr,
  input  logic [BYTE_W-1:0] buf_wdata,
  input  logic              buf_rd,
  output logic [BYTE_W-1:0] buf_rdata,
  output logic              buf_full,
  input  logic              rel_set,
  output logic              rel,
  output logic              upd_addr,
  output logic              overflow,
  output logic              event_p,
  output logic              xmit
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_v, filt_v;
  logic start_p, stop_p, rise_p, fall_p;

  assign raw_v = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cs_glitch_filter #(.STABLE_CYC(FILT_CYC)) i_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw_v[g]),
      .filt_o (filt_v[g])
    );
  end

  i2cs_bus_cond i_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (filt_v[0]),
    .sda_f   (filt_v[1]),
    .start_p (start_p),
    .stop_p  (stop_p),
    .rise_p  (rise_p),
    .fall_p  (fall_p)
  );

  i2cs_core i_core (
    .clk             (clk),
    .rst             (rst),
    .scl_f           (filt_v[0]),
    .sda_f           (filt_v[1]),
    .start_p         (start_p),
    .stop_p          (stop_p),
    .rise_p          (rise_p),
    .fall_p          (fall_p),
    .mode10_i        (mode10),
    .stretch_rx_en_i (stretch_rx_en),
    .own_wr_i        (own_wr),
    .own_wdata_i     (own_wdata),
    .buf_wr_i        (buf_wr),
    .buf_wdata_i     (buf_wdata),
    .buf_rd_i        (buf_rd),
    .rel_set_i       (rel_set),
    .scl_oe_o        (scl_oe),
    .sda_oe_o        (sda_oe),
    .buf_rdata_o     (buf_rdata),
    .buf_full_o      (buf_full),
    .rel_o           (rel),
    .ua_o            (upd_addr),
    .ovf_o           (overflow),
    .evt_o           (event_p),
    .xmit_o          (xmit)
  );
endmodule

// File: tb/test_i2c_stretch_slave.sv
module test_i2c_stretch_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst;
  logic m_scl, m_sda;
  logic scl_oe, sda_oe;
  logic mode10, stretch_rx_en, own_wr, buf_wr, buf_rd, rel_set;
  logic [9:0] own_wdata;
  logic [7:0] buf_wdata, buf_rdata;
  logic buf_full, rel, upd_addr, overflow, event_p, xmit;
  logic scl_line, sda_line;

  int n_run = 0, n_fail = 0, evt_cnt = 0;
  bit done = 0;
  logic [7:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;
  always @(posedge clk) if (event_p) evt_cnt++;

  i2c_stretch_slave i_i2c_stretch_slave (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .mode10(mode10), .stretch_rx_en(stretch_rx_en),
    .own_wr(own_wr), .own_wdata(own_wdata), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .buf_rd(buf_rd), .buf_rdata(buf_rdata), .buf_full(buf_full), .rel_set(rel_set),
    .rel(rel), .upd_addr(upd_addr), .overflow(overflow), .event_p(event_p), .xmit(xmit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(output logic s);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(HALF);
    s = sda_line;
    m_scl = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic m_start;
    m_sda = 1'b1; m_scl = 1'b1; wait_clk(HALF);
    m_sda = 1'b0; wait_clk(HALF);
    m_scl = 1'b0; wait_clk(HALF);
  endtask

  task automatic m_rstart;
    logic d;
    m_sda = 1'b1; wait_clk(HALF);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(HALF);
    m_sda = 1'b0; wait_clk(HALF);
    m_scl = 1'b0; wait_clk(HALF);
    d = 1'b0;
  endtask

  task automatic m_stop;
    m_sda = 1'b0; wait_clk(HALF);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(HALF);
    m_sda = 1'b1; wait_clk(HALF);
  endtask

  task automatic host_read;
    @(negedge clk); buf_rd = 1'b1; last_rd = buf_rdata;
    @(negedge clk); buf_rd = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] v);
    @(negedge clk); buf_wr = 1'b1; buf_wdata = v;
    @(negedge clk); buf_wr = 1'b0;
  endtask

  task automatic host_rel;
    @(negedge clk); rel_set = 1'b1;
    @(negedge clk); rel_set = 1'b0;
    wait_clk(3);
  endtask

  task automatic host_own(input logic [9:0] a);
    @(negedge clk); own_wr = 1'b1; own_wdata = a;
    @(negedge clk); own_wr = 1'b0;
    wait_clk(3);
  endtask

  task automatic write_byte(input logic [7:0] b, input bit early_rd, output logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      pulse(s);
    end
    m_sda = 1'b1;
    if (early_rd) host_read();
    pulse(nack);
  endtask

  task automatic read_byte(input bit ack, input bit early_ld, input logic [7:0] ld, output logic [7:0] v);
    logic s;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      pulse(s);
      v = {v[6:0], s};
    end
    m_sda = ~ack;
    if (early_ld) host_write(ld);
    pulse(s);
    m_sda = 1'b1;
  endtask

  task automatic t_reset;
    rst = 1'b1; wait_clk(5); rst = 1'b0; wait_clk(2);
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines", {scl_oe, sda_oe}, 0);
    chk(rel == 1, "R1 rel", rel, 1);
    chk({buf_full, upd_addr, overflow} == 0, "R1 flags", {buf_full, upd_addr, overflow}, 0);
  endtask

  task automatic t_addr_mismatch;
    logic nk; int e0;
    e0 = evt_cnt;
    m_start();
    write_byte(8'hB6, 0, nk);
    chk(nk == 1, "R2 mismatch NACK", nk, 1);
    write_byte(8'h11, 0, nk);
    chk(nk == 1 && buf_full == 0, "R2 ignored data", {nk, buf_full}, 2);
    chk(evt_cnt == e0 && scl_oe == 0, "R2 no event", evt_cnt - e0, 0);
    m_stop();
  endtask

  task automatic t_rx_stretch;
    logic nk; int e0;
    stretch_rx_en = 1'b1;
    e0 = evt_cnt;
    m_start();
    write_byte(8'hB4, 0, nk);
    chk(nk == 0, "R2 match ACK", nk, 0);
    chk(scl_oe == 0, "R2 no hold after write addr", scl_oe, 0);
    write_byte(8'h69, 0, nk);
    chk(nk == 0 && buf_full == 1 && buf_rdata == 8'h69, "R3 data in buffer", buf_rdata, 8'h69);
    chk(evt_cnt - e0 == 2, "R3 event count", evt_cnt - e0, 2);
    chk(rel == 0 && scl_oe == 1, "R4 hold", {rel, scl_oe}, 1);
    wait_clk(HALF);
    chk(scl_oe == 1, "R4 still held", scl_oe, 1);
    host_read();
    chk(last_rd == 8'h69 && scl_oe == 1, "R4 held until release", scl_oe, 1);
    host_rel();
    chk(rel == 1 && scl_oe == 0, "R12 release", {rel, scl_oe}, 2);
    m_stop();
  endtask

  task automatic t_rx_early;
    logic nk;
    stretch_rx_en = 1'b1;
    m_start();
    write_byte(8'hB4, 0, nk);
    write_byte(8'hC3, 1, nk);
    chk(last_rd == 8'hC3, "R5 early read value", last_rd, 8'hC3);
    chk(rel == 1 && scl_oe == 0 && buf_full == 0, "R5 no hold", {rel, scl_oe, buf_full}, 4);
    m_stop();
  endtask

  task automatic t_rx_overflow;
    logic nk;
    stretch_rx_en = 1'b0;
    m_start();
    write_byte(8'hB4, 0, nk);
    write_byte(8'h12, 0, nk);
    chk(nk == 0 && rel == 1 && scl_oe == 0, "R6 no hold when disabled", {nk, rel, scl_oe}, 2);
    write_byte(8'h34, 0, nk);
    chk(nk == 1 && overflow == 1, "R7 overflow NACK", {nk, overflow}, 3);
    chk(buf_rdata == 8'h12, "R7 buffer kept", buf_rdata, 8'h12);
    m_stop();
    host_read();
    wait_clk(2);
    chk(overflow == 0 && buf_full == 0, "R7 read clears", {overflow, buf_full}, 0);
  endtask

  task automatic t_tx7;
    logic nk; logic [7:0] v;
    stretch_rx_en = 1'b0;
    m_start();
    write_byte(8'hB5, 0, nk);
    chk(nk == 0 && xmit == 1, "R8 read addr ACK", {nk, xmit}, 1);
    chk(rel == 0 && scl_oe == 1, "R8 hold when empty", {rel, scl_oe}, 1);
    host_write(8'hA3);
    host_rel();
    read_byte(1, 1, 8'h5C, v);
    chk(v == 8'hA3, "R8 first byte", v, 8'hA3);
    chk(rel == 1 && scl_oe == 0, "R8 no hold when loaded", {rel, scl_oe}, 2);
    read_byte(0, 0, 8'h00, v);
    chk(v == 8'h5C, "R8 second byte", v, 8'h5C);
    chk(scl_oe == 0, "R8 no hold after NACK", scl_oe, 0);
    m_stop();
  endtask

  task automatic t_addr10;
    logic nk; logic [7:0] v; int e0;
    mode10 = 1'b1; stretch_rx_en = 1'b1;
    host_own(10'h2C7);
    e0 = evt_cnt;
    m_start();
    write_byte(8'hF4, 0, nk);
    chk(nk == 0 && upd_addr == 1 && scl_oe == 1, "R9 header hold", {nk, upd_addr, scl_oe}, 3);
    chk(rel == 1, "R9 rel untouched", rel, 1);
    host_own(10'h2C7);
    chk(upd_addr == 0 && scl_oe == 0, "R9 release by addr write", {upd_addr, scl_oe}, 0);
    write_byte(8'hC7, 0, nk);
    chk(nk == 0 && upd_addr == 1 && scl_oe == 1 && rel == 1, "R9 low byte hold", {nk, upd_addr, scl_oe, rel}, 7);
    host_own(10'h2C7);
    write_byte(8'h3C, 0, nk);
    chk(nk == 0 && buf_rdata == 8'h3C && rel == 0, "R9 data rx hold", buf_rdata, 8'h3C);
    host_read();
    host_rel();
    m_rstart();
    write_byte(8'hF5, 0, nk);
    chk(nk == 0 && upd_addr == 0 && xmit == 1, "R10 read header", {nk, upd_addr, xmit}, 1);
    chk(rel == 0 && scl_oe == 1, "R10 tx hold", {rel, scl_oe}, 1);
    host_write(8'h96);
    host_rel();
    read_byte(0, 0, 8'h00, v);
    chk(v == 8'h96, "R10 byte", v, 8'h96);
    chk(evt_cnt - e0 == 5, "R3 10-bit events", evt_cnt - e0, 5);
    m_stop();
  endtask

  task automatic t_stop_clears;
    logic nk;
    m_start();
    write_byte(8'hF5, 0, nk);
    chk(nk == 1 && xmit == 0 && scl_oe == 0, "R11 match cleared", {nk, xmit, scl_oe}, 4);
    m_stop();
    mode10 = 1'b0;
  endtask

  initial begin
    m_scl = 1'b1; m_sda = 1'b1;
    mode10 = 1'b0; stretch_rx_en = 1'b0;
    own_wr = 1'b0; own_wdata = '0; buf_wr = 1'b0; buf_wdata = '0;
    buf_rd = 1'b0; rel_set = 1'b0; last_rd = '0;
    t_reset();
    host_own(10'h05A);
    t_addr_mismatch();
    t_rx_stretch();
    t_rx_early();
    t_rx_overflow();
    t_tx7();
    t_addr10();
    t_stop_clears();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule